// File: doc/BRIEF.md
# Incremental Folded Branch-History Register

This block keeps a compressed image of the most recent `HIST_LEN` bits of global branch outcome history in `FOLD_LEN` bits. History bit j (j = 0 is the newest) is folded onto position `j mod FOLD_LEN`, and all bits landing on the same position are XORed together. Predictor tables use the image directly as an index or tag hash, so no wide XOR tree sits on the lookup path.

Each cycle the owner reports how many new outcomes enter the history (`upd_num`, 0 up to `MAX_UPD`) and whether the last of them was taken. Every earlier outcome in the same group counts as not taken. The owner also supplies the history bits that are about to leave the window, which it reads from its own circular history buffer. The register does not rebuild the fold. It cancels the leaving bits, inserts the new bits at fixed positions, and rotates the result by the update count. When the window is no longer than the folded width, the update is a plain shift.

The block accepts an update on every clock and never stalls, so the edge has no valid/ready pair and no back-pressure. An update of zero is the idle case.

Top module: `fold_hist_reg`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge makes `folded` all zeros after that edge. Reset takes priority over any update.
- R2: With `upd_num` = 0, `folded` keeps its value at the next edge whatever `upd_taken` and `old_bits` carry.
- R3: One edge after each update, `folded[k]` equals the XOR of all history bits h[j] with j < `HIST_LEN` and j mod `FOLD_LEN` = k, where h[0] is the newest outcome.
- R4: An update of n outcomes shifts n bits into the history. The newest of them (h[0]) is `upd_taken`, and the other n-1 are 0.
- R5: `upd_num` stays within 0..`MAX_UPD`. `old_bits[i]` must carry history bit h[`HIST_LEN`-1-i] as it stands before the update. Bits with i >= `upd_num` are ignored.
- R6: When `HIST_LEN` <= `FOLD_LEN`, the value shifts left by `upd_num`, the taken flag enters bit 0, and bits at and above `HIST_LEN` stay zero.
- R7: When a leaving bit has not wrapped (`HIST_LEN`-1-i < `FOLD_LEN`), it is removed by clearing the folded bit that holds it, and it is not XORed. The result still satisfies R3 when `HIST_LEN` is only slightly larger than `FOLD_LEN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_num | input | $clog2(MAX_UPD+1) | Number of outcomes entering the history this cycle |
| upd_taken | input | 1 | Direction of the newest entering outcome |
| old_bits | input | MAX_UPD | Leaving history bits; bit i is h[HIST_LEN-1-i] |
| folded | output | FOLD_LEN | Folded history image |

## Verification
The bench builds four copies from one stimulus stream. The first has a 13-bit window folded to 8 bits, where the leaving bits wrap and are XORed out. The second has a 9-bit window folded to 8 bits, where the second leaving bit does not wrap and must be cleared instead. The third has a 6-bit window folded to 8 bits, which selects the plain shift path. The fourth has a 32-bit window folded to 11 bits, where several chunks stack onto each position. Between them, every update path and every masking rule is driven for update counts 0, 1 and 2. Unused leaving-bit inputs are driven with random values to confirm that they are ignored.

// File: rtl/fhist_pkg.sv
package fhist_pkg;

  // Folded position of the i-th leaving bit (history index L-1-i)
  function automatic int fh_leave_pos(int hist_len, int fold_len, int i);
    return (hist_len - 1 - i) % fold_len;
  endfunction

  // A leaving bit is XORed out only if it wrapped onto a lower chunk
  function automatic bit fh_leave_wraps(int hist_len, int fold_len, int i);
    return (hist_len - 1 - i) >= fold_len;
  endfunction

endpackage

// File: rtl/fhist_merge.sv
module fhist_merge
  import fhist_pkg::*;
#(
  parameter int HIST_LEN = 13,
  parameter int FOLD_LEN = 8,
  parameter int MAX_UPD  = 2,
  parameter int NUM_W    = $clog2(MAX_UPD + 1)
) (
  input  logic [FOLD_LEN-1:0] cur,
  input  logic [NUM_W-1:0]    num,
  input  logic                taken,
  input  logic [MAX_UPD-1:0]  old_bits,
  output logic [FOLD_LEN-1:0] merged
);

  logic [31:0]         num32;
  logic [FOLD_LEN-1:0] keep;
  logic [MAX_UPD-1:0]  old_m;
  logic [MAX_UPD-1:0]  new_m;

  assign num32 = 32'(num);

  // Folded bits whose content slides beyond the window are dropped
  for (genvar k = 0; k < FOLD_LEN; k++) begin : g_keep
    assign keep[k] = cur[k] & ~(num32 >= 32'(HIST_LEN - k));
  end

  for (genvar i = 0; i < MAX_UPD; i++) begin : g_slot
    assign old_m[i] = old_bits[i] & (num32 > 32'(i));
    assign new_m[i] = taken & (num32 == 32'(i + 1));
  end

  always_comb begin
    merged = keep;
    for (int i = 0; i < MAX_UPD; i++) begin
      if (fh_leave_wraps(HIST_LEN, FOLD_LEN, i))
        merged[fh_leave_pos(HIST_LEN, FOLD_LEN, i)] ^= old_m[i];
      merged[FOLD_LEN-1-i] ^= new_m[i];
    end
  end

  // R2
  always_comb begin
    if (num == '0) idle_passthru_chk : assert (merged == cur);
  end

endmodule

// File: rtl/fhist_rotl.sv
module fhist_rotl #(
  parameter int FOLD_LEN = 8,
  parameter int MAX_UPD  = 2,
  parameter int NUM_W    = $clog2(MAX_UPD + 1)
) (
  input  logic [FOLD_LEN-1:0] din,
  input  logic [NUM_W-1:0]    amt,
  output logic [FOLD_LEN-1:0] dout
);

  logic [2*FOLD_LEN-1:0] dbl;
  logic [FOLD_LEN-1:0]   cand [MAX_UPD+1];

  assign dbl = {din, din};

  for (genvar s = 0; s <= MAX_UPD; s++) begin : g_amt
    assign cand[s] = dbl[2*FOLD_LEN-1-s -: FOLD_LEN];
  end

  assign dout = (32'(amt) <= 32'(MAX_UPD)) ? cand[amt] : din;

  // R3
  always_comb begin
    rot_ones_chk : assert ($countones(dout) == $countones(din));
  end

endmodule

// File: rtl/fhist_short.sv
module fhist_short #(
  parameter int HIST_LEN = 6,
  parameter int FOLD_LEN = 8,
  parameter int MAX_UPD  = 2,
  parameter int NUM_W    = $clog2(MAX_UPD + 1)
) (
  input  logic [FOLD_LEN-1:0] cur,
  input  logic [NUM_W-1:0]    num,
  input  logic                taken,
  output logic [FOLD_LEN-1:0] nxt
);

  localparam logic [FOLD_LEN-1:0] WIN_MASK = {FOLD_LEN{1'b1}} >> (FOLD_LEN - HIST_LEN);

  logic [FOLD_LEN-1:0] shifted;
  logic                ins;

  assign ins     = taken & (num != '0);
  assign shifted = cur << num;
  assign nxt     = (shifted | FOLD_LEN'(ins)) & WIN_MASK;

endmodule

// File: rtl/fold_hist_reg.sv
module fold_hist_reg #(
  parameter int HIST_LEN = 13,
  parameter int FOLD_LEN = 8,
  parameter int MAX_UPD  = 2,
  localparam int NUM_W   = $clog2(MAX_UPD + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_W-1:0]    upd_num,
  input  logic                upd_taken,
  input  logic [MAX_UPD-1:0]  old_bits,
  output logic [FOLD_LEN-1:0] folded
);

  localparam bit WRAPPING = HIST_LEN > FOLD_LEN;

  logic [FOLD_LEN-1:0] nxt;

  if (WRAPPING) begin : g_wrap
    logic [FOLD_LEN-1:0] merged;

    fhist_merge #(
      .HIST_LEN(HIST_LEN), .FOLD_LEN(FOLD_LEN), .MAX_UPD(MAX_UPD), .NUM_W(NUM_W)
    ) u_merge (
      .cur(folded), .num(upd_num), .taken(upd_taken),
      .old_bits(old_bits), .merged(merged)
    );

    fhist_rotl #(
      .FOLD_LEN(FOLD_LEN), .MAX_UPD(MAX_UPD), .NUM_W(NUM_W)
    ) u_rot (
      .din(merged), .amt(upd_num), .dout(nxt)
    );
  end else begin : g_plain
    fhist_short #(
      .HIST_LEN(HIST_LEN), .FOLD_LEN(FOLD_LEN), .MAX_UPD(MAX_UPD), .NUM_W(NUM_W)
    ) u_shift (
      .cur(folded), .num(upd_num), .taken(upd_taken), .nxt(nxt)
    );
  end

  always_ff @(posedge clk) begin
    if (rst) folded <= '0;
    else     folded <= nxt;
  end

  // Parity of the bits leaving the window (inputs per R5)
  logic leave_par;
  always_comb begin
    leave_par = 1'b0;
    for (int i = 0; i < MAX_UPD; i++)
      if (32'(upd_num) > 32'(i)) leave_par ^= old_bits[i];
  end

  // R1
  rst_clear_chk : assert property (@(posedge clk) rst |=> folded == '0);

  // R2
  idle_hold_chk : assert property (@(posedge clk) disable iff (rst)
    (upd_num == '0) |=> $stable(folded));

  // R5
  num_range_chk : assert property (@(posedge clk) disable iff (rst)
    32'(upd_num) <= 32'(MAX_UPD));

  // R3
  fold_parity_chk : assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (^folded) == $past((^folded) ^ leave_par ^ (upd_taken & (upd_num != '0))));

  if (!WRAPPING) begin : g_plain_chk
    // R6
    plain_lsb_chk : assert property (@(posedge clk) disable iff (rst)
      (upd_num != '0) |=> folded[0] == $past(upd_taken));
  end

endmodule

// File: tb/sim_fold_hist_reg.sv
`timescale 1ns/1ps
module sim_fold_hist_reg;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1;
  logic [1:0] num = '0;
  logic       taken = 1'b0;
  logic [1:0] o0 = '0, o1 = '0, o2 = '0, o3 = '0;
  logic [7:0]  f0, f1, f2;
  logic [10:0] f3;

  fold_hist_reg #(.HIST_LEN(13), .FOLD_LEN(8),  .MAX_UPD(2)) u0 (
    .clk(clk), .rst(rst), .upd_num(num), .upd_taken(taken), .old_bits(o0), .folded(f0));
  fold_hist_reg #(.HIST_LEN(9),  .FOLD_LEN(8),  .MAX_UPD(2)) u1 (
    .clk(clk), .rst(rst), .upd_num(num), .upd_taken(taken), .old_bits(o1), .folded(f1));
  fold_hist_reg #(.HIST_LEN(6),  .FOLD_LEN(8),  .MAX_UPD(2)) u2 (
    .clk(clk), .rst(rst), .upd_num(num), .upd_taken(taken), .old_bits(o2), .folded(f2));
  fold_hist_reg #(.HIST_LEN(32), .FOLD_LEN(11), .MAX_UPD(2)) u3 (
    .clk(clk), .rst(rst), .upd_num(num), .upd_taken(taken), .old_bits(o3), .folded(f3));

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  bit  hist[$];
  string phase = "R3";

  function automatic logic [15:0] fold_exp(int L, int C);
    logic [15:0] e = '0;
    for (int j = 0; j < L; j++) e[j % C] ^= hist[j];
    return e;
  endfunction

  function automatic logic [1:0] old_of(int L, int n);
    logic [1:0] v;
    for (int i = 0; i < 2; i++)
      v[i] = (i < n) ? hist[L-1-i] : 1'($urandom);
    return v;
  endfunction

  task automatic cmp(string tag, string name, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, name, act, exp);
    end
  endtask

  task automatic cycle(input int n, input bit tk, input bit r);
    string t;
    @(negedge clk);
    rst   = r;
    num   = 2'(n);
    taken = tk;
    o0 = old_of(13, n);
    o1 = old_of(9, n);
    o2 = old_of(6, n);
    o3 = old_of(32, n);
    @(posedge clk);
    #1;
    if (r) begin
      foreach (hist[j]) hist[j] = 1'b0;
    end else begin
      for (int s = 0; s < n; s++) hist.push_front((s == n-1) ? tk : 1'b0);
      while (hist.size() > 64) void'(hist.pop_back());
    end
    t = r ? "R1" : (n == 0 ? "R2" : phase);
    cmp(t, "u0", 16'(f0), fold_exp(13, 8));
    cmp(r || n == 0 ? t : "R7", "u1", 16'(f1), fold_exp(9, 8));
    cmp(r || n == 0 ? t : "R6", "u2", 16'(f2), fold_exp(6, 8));
    cmp(t, "u3", 16'(f3), fold_exp(32, 11));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < 64; j++) hist.push_back(1'b0);
    // R1: reset state with updates pending
    cycle(2, 1, 1);
    cycle(1, 1, 1);
    // R3: mixed random traffic
    phase = "R3";
    for (int k = 0; k < 3000; k++) cycle($urandom_range(0, 2), 1'($urandom), 0);
    // R4: long runs of two-outcome updates with the last taken
    phase = "R4";
    for (int k = 0; k < 200; k++) cycle(2, 1, 0);
    for (int k = 0; k < 200; k++) cycle(1 + (k % 2), 1'(k % 3 == 0), 0);
    // R2: idle cycles with noisy taken flag
    for (int k = 0; k < 100; k++) cycle(0, 1'($urandom), 0);
    // R5: unused leaving bits are randomised on every call
    phase = "R5";
    for (int k = 0; k < 400; k++) cycle($urandom_range(0, 1), 1'($urandom), 0);
    // R1: reset in the middle of traffic
    cycle(2, 1, 1);
    phase = "R3";
    for (int k = 0; k < 1000; k++) cycle($urandom_range(0, 2), 1'($urandom), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule